// File: doc/BRIEF.md
# Crossing-Aligned SECDED Link Frame Codec

This block carries three 8-bit tower channel values over one serial lane per 25 ns bunch crossing. When a crossing strobe arrives, the transmit half captures the three channel bytes and computes a check byte. That byte holds five Hamming parity bits over the 24 data bits, plus one overall parity bit. The transmit half then emits the four-byte frame one byte per cycle, on a clock at four times the crossing rate. It marks the first byte with a frame-start flag. The byte stream goes to an 8B/10B line coder, which is outside this block. Sixteen such lanes together carry 48 channels, at 160 MB/s per lane and 1.6 Gb/s on the line.

The receive half collects a frame from the byte stream, starting at the frame-start flag. On the check byte it computes a syndrome and an overall parity. It repairs any single flipped bit, flags a two-bit error as uncorrectable, and presents the three channel bytes as one word. The two halves share a clock and reset but are otherwise independent, so they can serve the two ends of a link.

Top module: `link_frame_codec`

## Requirements
- R1: While reset is active and after it is released, `tx_valid`, `tx_sof`, `overrun`, `out_valid`, `err_fixed` and `err_fatal` are all 0.
- R2: An accepted strobe captures `ch_in`, and from the next cycle on four bytes appear on consecutive cycles with `tx_valid` high. In order they are `ch_in[7:0]`, `ch_in[15:8]`, `ch_in[23:16]` and then the check byte. `tx_sof` is high only with the first of them.
- R3: The check byte is computed as follows. Data bit j maps to codeword position c(j), the j-th integer (counting from 0) of 3,5,6,7,9,… that is not a power of two. Check bit i (i = 0..4) is the XOR of every data bit whose c(j) has bit i set. Check bit 5 is the XOR of all 24 data bits and check bits 4:0. Check bits 7:6 are 0.
- R4: A strobe is accepted when no frame is being sent, and also on the cycle the check byte is shown. Strobes every four cycles therefore give back-to-back frames with no idle byte.
- R5: A strobe on a cycle when byte 0, 1 or 2 of a frame is shown is ignored, and the frame in flight completes unchanged. Such a strobe sets `overrun`, which stays 1 until reset.
- R6: The receiver starts a frame on a byte with `rx_valid` and `rx_sof` both high. The next three bytes with `rx_valid` high and `rx_sof` low complete the frame, and cycles with `rx_valid` low may fall between them. `out_valid` is high for exactly the one cycle after the check byte is taken.
- R7: For an error-free frame, `out_data` equals the three received data bytes, and `err_fixed` and `err_fatal` are 0.
- R8: If exactly one of the 24 data bits or check bits 5:0 is inverted, `out_data` holds the original data, `err_fixed` is 1 and `err_fatal` is 0.
- R9: If exactly two of those 30 bits are inverted, `err_fatal` is 1 and `err_fixed` is 0. The two flags are never high together, and each is high only together with `out_valid`.
- R10: Valid bytes without `rx_sof` outside a frame are ignored and produce no `out_valid`. A byte with `rx_sof` in the middle of a frame drops the partial frame and starts a new one.
- R11: The receiver ignores check bits 7:6. Inverting them changes neither `out_data` nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, four cycles per crossing |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_stb | input | 1 | Crossing strobe, captures `ch_in` |
| ch_in | input | 24 | Three channel bytes, channel 0 in bits 7:0 |
| tx_byte | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | `tx_byte` carries a frame byte |
| tx_sof | output | 1 | First byte of a frame |
| overrun | output | 1 | Sticky: strobe arrived mid-frame |
| rx_byte | input | 8 | Incoming frame byte |
| rx_valid | input | 1 | `rx_byte` is valid |
| rx_sof | input | 1 | `rx_byte` is the first byte of a frame |
| out_data | output | 24 | Recovered channel bytes |
| out_valid | output | 1 | One-cycle pulse, `out_data` and flags are fresh |
| err_fixed | output | 1 | A single-bit error was corrected |
| err_fatal | output | 1 | A double-bit error was detected |

## Verification
The bench builds the block with its defaults: 8-bit channels and three channels per frame, which gives five Hamming bits and a 30-bit protected codeword. With that size the bench can invert every one of the 30 protected positions in turn and check the correction of each. It also covers a spread of two-bit pairs, including pairs that involve the overall parity bit. On the transmit side, the four-cycle frame lets the bench place strobes on each byte slot, so both back-to-back acceptance and the overrun window are reached.

// File: rtl/link_frame_codec.sv
module link_frame_codec #(
  parameter int CH_W = 8,
  parameter int NCH  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xing_stb,
  input  logic [CH_W*NCH-1:0] ch_in,
  output logic [CH_W-1:0]     tx_byte,
  output logic                tx_valid,
  output logic                tx_sof,
  output logic                overrun,
  input  logic [CH_W-1:0]     rx_byte,
  input  logic                rx_valid,
  input  logic                rx_sof,
  output logic [CH_W*NCH-1:0] out_data,
  output logic                out_valid,
  output logic                err_fixed,
  output logic                err_fatal
);
  function automatic int par_bits(input int n);
    for (int r = 1; r < 16; r++)
      if ((1 << r) >= n + r + 1) return r;
    return 16;
  endfunction

  localparam int DATA_W = CH_W * NCH;
  localparam int PAR_W  = par_bits(DATA_W);
  localparam int NB     = NCH + 1;
  localparam int IW     = $clog2(NB);

  function automatic int hpos(input int j);
    int k;
    k = 0;
    for (int p = 3; p < 256; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (k == j) return p;
        k++;
      end
    end
    return 0;
  endfunction

  function automatic logic [PAR_W-1:0] syn(input logic [DATA_W-1:0] d);
    logic [PAR_W-1:0] s;
    int p;
    s = '0;
    for (int j = 0; j < DATA_W; j++) begin
      p = hpos(j);
      for (int i = 0; i < PAR_W; i++)
        if (((p >> i) & 1) != 0) s[i] = s[i] ^ d[j];
    end
    return s;
  endfunction

  // transmit side
  logic [NB*CH_W-1:0] frm;
  logic [IW-1:0]      ph;
  logic               busy;

  wire [PAR_W-1:0] tpar = syn(ch_in);
  wire             tall = ^{ch_in, tpar};
  wire [CH_W-1:0]  chk  = CH_W'({tall, tpar});
  wire             last = busy && (ph == IW'(NB - 1));
  wire             take = xing_stb && (!busy || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ph      <= '0;
      overrun <= 1'b0;
      frm     <= '0;
    end else begin
      if (xing_stb && !take) overrun <= 1'b1;
      if (take) begin
        frm  <= {chk, ch_in};
        ph   <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        ph <= ph + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  assign tx_byte  = frm[ph*CH_W +: CH_W];
  assign tx_valid = busy;
  assign tx_sof   = busy && (ph == '0);

  // receive side
  logic [DATA_W-1:0] rbuf;
  logic [IW-1:0]     ridx;
  logic              ract;
  logic [DATA_W-1:0] flip;

  wire [PAR_W-1:0] rsyn = syn(rbuf) ^ rx_byte[PAR_W-1:0];
  wire             rall = ^{rbuf, rx_byte[PAR_W:0]};
  wire             fin  = rx_valid && !rx_sof && ract && (ridx == IW'(NCH));
  wire             unused_hi = ^rx_byte[CH_W-1:PAR_W+1];

  always_comb
    for (int j = 0; j < DATA_W; j++) flip[j] = (hpos(j) == int'(rsyn));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbuf      <= '0;
      ridx      <= '0;
      ract      <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      err_fixed <= 1'b0;
      err_fatal <= 1'b0;
    end else begin
      if (rx_valid && rx_sof) begin
        rbuf[CH_W-1:0] <= rx_byte;
        ridx           <= IW'(1);
        ract           <= 1'b1;
      end else if (rx_valid && ract) begin
        if (fin) ract <= 1'b0;
        else begin
          rbuf[ridx*CH_W +: CH_W] <= rx_byte;
          ridx                    <= ridx + 1'b1;
        end
      end
      out_valid <= fin;
      if (fin) out_data <= rall ? (rbuf ^ flip) : rbuf;
      err_fixed <= fin && rall;
      err_fatal <= fin && !rall && (rsyn != '0);
    end
  end
endmodule

module link_frame_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic xing_stb,
  input logic tx_valid,
  input logic tx_sof,
  input logic overrun,
  input logic out_valid,
  input logic err_fixed,
  input logic err_fatal
);
  assert_sof_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |-> tx_valid);
  assert_sof_then_body_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |=> (tx_valid && !tx_sof));
  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_overrun_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(xing_stb));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_fixed && err_fatal));
  assert_flags_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_fixed || err_fatal) |-> out_valid);
endmodule

bind link_frame_codec link_frame_codec_chk u_chk (.*);

// File: tb/test_link_frame_codec.sv
module test_link_frame_codec;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xing_stb = 1'b0;
  logic [23:0] ch_in = '0;
  logic [7:0]  tx_byte;
  logic        tx_valid, tx_sof, overrun;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0;
  logic [23:0] out_data;
  logic        out_valid, err_fixed, err_fatal;

  always #(CLK_P/2) clk = ~clk;

  link_frame_codec i_link_frame_codec (.*);

  int total = 0, bad = 0;
  logic [7:0] q[$];
  bit         sq[$];
  bit         ov_m = 1'b0;

  function automatic logic [7:0] enc(input logic [23:0] d);
    bit cw[32];
    int k;
    logic [7:0] c;
    k = 0;
    c = '0;
    for (int p = 1; p < 30; p++) begin
      cw[p] = 1'b0;
      if ((p & (p - 1)) != 0) begin cw[p] = d[k]; k++; end
    end
    for (int i = 0; i < 5; i++)
      for (int p = 3; p < 30; p++)
        if ((p & (p - 1)) != 0 && ((p >> i) & 1) == 1) c[i] = c[i] ^ cw[p];
    c[5] = ^d ^ ^c[4:0];
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit s, input logic [23:0] d, input bit v, input bit sf,
                      input logic [7:0] b, input bit eo, input logic [23:0] ed,
                      input bit efx, input bit eft, input string tag);
    bit acc;
    xing_stb = s; ch_in = d; rx_valid = v; rx_sof = sf; rx_byte = b;
    @(posedge clk);
    acc = s && (q.size() <= 1);
    if (q.size() > 0) begin void'(q.pop_front()); void'(sq.pop_front()); end
    if (acc) begin
      q.push_back(d[7:0]);   sq.push_back(1'b1);
      q.push_back(d[15:8]);  sq.push_back(1'b0);
      q.push_back(d[23:16]); sq.push_back(1'b0);
      q.push_back(enc(d));   sq.push_back(1'b0);
    end else if (s) ov_m = 1'b1;
    @(negedge clk);
    chk({tag, " tx_valid"}, 32'(tx_valid), 32'(q.size() > 0));
    if (q.size() > 0) begin
      chk({tag, " tx_sof"}, 32'(tx_sof), 32'(sq[0]));
      chk({tag, " tx_byte"}, 32'(tx_byte), 32'(q[0]));
    end
    chk("R5 overrun", 32'(overrun), 32'(ov_m));
    chk({tag, " out_valid"}, 32'(out_valid), 32'(eo));
    chk({tag, " err_fixed"}, 32'(err_fixed), 32'(eo && efx));
    chk({tag, " err_fatal"}, 32'(err_fatal), 32'(eo && eft));
    if (eo && !eft) chk({tag, " out_data"}, 32'(out_data), 32'(ed));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, '0, 0, '0, 0, 0, tag);
  endtask

  task automatic rxf(input logic [23:0] d, input logic [31:0] m, input int kind, input string tag);
    logic [31:0] f;
    f = {enc(d), d} ^ m;
    for (int k = 0; k < 4; k++)
      step(0, '0, 1, k == 0, f[k*8 +: 8], k == 3, d, kind == 1, kind == 2, tag);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    rst_n = 1'b1;
    idle(2, "R1 idle");

    step(1, 24'hC3B2A1, 0, 0, '0, 0, '0, 0, 0, "R2 R3 single");
    idle(5, "R2 R3 single");

    for (int f = 0; f < 5; f++) begin
      logic [23:0] d;
      d = (f == 0) ? 24'h000000 : (f == 1) ? 24'hFFFFFF : 24'h5A3C0F ^ (24'h01_2345 * f);
      step(1, d, 0, 0, '0, 0, '0, 0, 0, "R4 back-to-back");
      idle(3, "R4 back-to-back");
    end
    idle(3, "R4 drain");
    step(1, 24'h800001, 0, 0, '0, 0, '0, 0, 0, "R4 late strobe");
    idle(4, "R4 gap");
    step(1, 24'h123456, 0, 0, '0, 0, '0, 0, 0, "R3 after gap");
    idle(5, "R3 after gap");

    rxf(24'h0F1E2D, 32'h0, 0, "R6 R7 clean");
    rxf(24'h000000, 32'h0, 0, "R7 zero");
    for (int b = 0; b < 30; b++)
      rxf(24'h9A7B5C ^ 24'(b * 24'h0B1D3), 32'h1 << b, 1, "R8 single flip");
    for (int b = 0; b < 29; b += 2)
      rxf(24'h3C5A96 ^ 24'(b), (32'h1 << b) | (32'h1 << ((b * 7 + 3) % 30 == b ? b + 1 : (b * 7 + 3) % 30)), 2, "R9 double flip");
    rxf(24'h77AA11, 32'h1 << 29 | 32'h1 << 5, 2, "R9 double with overall");
    rxf(24'h445566, 32'hC000_0000, 0, "R11 spare bits");

    step(0, '0, 1, 0, 8'h11, 0, '0, 0, 0, "R10 stray");
    step(0, '0, 1, 0, 8'h22, 0, '0, 0, 0, "R10 stray");
    step(0, '0, 1, 0, 8'h33, 0, '0, 0, 0, "R10 stray");
    step(0, '0, 1, 0, 8'h44, 0, '0, 0, 0, "R10 stray");
    idle(1, "R10 stray");

    step(0, '0, 1, 1, 8'hEE, 0, '0, 0, 0, "R10 restart");
    step(0, '0, 1, 0, 8'hDD, 0, '0, 0, 0, "R10 restart");
    rxf(24'hABCDEF, 32'h0, 0, "R10 restart");

    begin
      logic [31:0] f;
      f = {enc(24'h135724), 24'h135724} ^ 32'h0000_0100;
      step(0, '0, 1, 1, f[7:0], 0, '0, 0, 0, "R6 gaps");
      idle(2, "R6 gaps");
      step(0, '0, 1, 0, f[15:8], 0, '0, 0, 0, "R6 gaps");
      idle(1, "R6 gaps");
      step(0, '0, 1, 0, f[23:16], 0, '0, 0, 0, "R6 gaps");
      idle(3, "R6 gaps");
      step(0, '0, 1, 0, f[31:24], 1, 24'h135724, 1, 0, "R6 R8 gaps");
      idle(2, "R6 gaps");
    end

    step(1, 24'hA5A5A5, 0, 0, '0, 0, '0, 0, 0, "R5 first");
    step(1, 24'h5A5A5A, 0, 0, '0, 0, '0, 0, 0, "R5 overrun strobe");
    step(1, 24'h0000FF, 0, 0, '0, 0, '0, 0, 0, "R5 overrun strobe");
    idle(6, "R5 sticky");

    finish_up();
  end
endmodule